// File: doc/BRIEF.md
# Write-Once Nonvolatile-Memory Timing Tick Generator

This block derives the timing strobe that a nonvolatile memory controller uses to pace its erase and program pulses. It divides the bus-rate clock by a programmable ratio and emits a single-cycle tick once per divided period. It does not produce a derived clock. One tick marks one program/erase timing unit. Software picks the ratio so that the tick rate falls between 150 kHz and 200 kHz, which gives units of about 5 µs to 6.7 µs. For example, a 20 MHz bus with the prescaler on and a divisor of 12 gives about 192.3 kHz.

The ratio lives in an 8-bit configuration register that accepts exactly one write after reset. Bit 6 selects a fixed divide-by-8 stage ahead of the main counter, and bits 5:0 hold a divisor N. With the prescaler off the period is N+1 bus cycles. With it on the period is 8×(N+1) bus cycles. Bit 7 is a read-only flag that the first write sets, whatever data is written. The flag gates the erase/program enable output and the tick. Both counters sit cleared until the flag is set and then count from zero.

Top module: `nvm_tick_gen`

## Requirements
- R1: After reset, rd_data is 8'h00, pe_enable is 0 and tick is 0.
- R2: The first write after reset sets rd_data[7] (the loaded flag) whatever the written data is. In the same write, wr_data[6] is stored as the prescale select and wr_data[5:0] is stored as divisor N. wr_data[7] is never stored.
- R3: Once the flag is set, further writes leave rd_data and the tick period unchanged until the next reset.
- R4: rd_data always shows {flag, prescale select, N}, with the flag at bit 7, the prescale select at bit 6 and N at bits 5:0.
- R5: pe_enable is 1 exactly when the loaded flag is 1.
- R6: With prescale select 0, tick is high for one cycle once every N+1 bus cycles. When N=0, tick is high on every cycle.
- R7: With prescale select 1, tick is high for one cycle once every 8×(N+1) bus cycles.
- R8: Counting starts from zero. If P is the period, the first tick is high during the P-th cycle after the clock edge that captured the first write.
- R9: tick stays 0 while the loaded flag is 0.
- R10: A write presented in a cycle where rst is high is ignored.
- R11: A reset after loading clears the flag and the configuration, and the next write is accepted as a first write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Loaded flag and current configuration |
| tick | output | 1 | One-cycle pulse per divided period |
| pe_enable | output | 1 | Erase/program permitted |

## Verification
The bench targets the edges of the ratio range: N=0 without the prescaler, where the tick never drops, and the largest ratio, 8×64. A counter that is off by one, or that forgets the prescale factor, shows up as a wrong first-tick cycle or a wrong interval. Writing 8'h00 checks that the flag does not depend on the data. A write with bit 7 set checks that bit 7 is not stored as data. A second write is used to expose a register that fails to lock, because the read value and the period would both change. A write held together with reset, and a reset after loading, expose a lock that survives reset or a capture that ignores reset.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;

    localparam int DIV_W = 6;
    localparam int PRE_W = 3;
    localparam int REG_W = DIV_W + 2;

    typedef struct packed {
        logic             prescale;
        logic [DIV_W-1:0] divisor;
    } div_cfg_t;

    function automatic logic [REG_W-1:0] status_word(input logic loaded, input div_cfg_t cfg);
        return {loaded, cfg};
    endfunction

endpackage

// File: rtl/nvm_cfg_lock.sv
module nvm_cfg_lock
    import nvm_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-2:0] wr_cfg,
    output logic             loaded,
    output div_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= 1'b0;
            cfg    <= '0;
        end else if (wr_en && !loaded) begin
            loaded <= 1'b1;
            cfg    <= div_cfg_t'(wr_cfg);
        end
    end

    // R2
    first_write_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !loaded) |=> loaded);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        loaded |=> (loaded && $stable(cfg)));

endmodule

// File: rtl/nvm_prescale.sv
module nvm_prescale #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic use_pre,
    output logic stb
);

    generate
        if (PRE_W == 0) begin : g_none
            assign stb = run;
        end else begin : g_cnt
            logic [PRE_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (use_pre) begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign stb = run && (!use_pre || (cnt == '1));

            // R8
            pre_held_chk: assert property (@(posedge clk) disable iff (rst)
                !run |=> (cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/nvm_div_count.sv
module nvm_div_count #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stb,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && stb && at_end;

    // R8
    div_held_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R6
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit));

endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen
    import nvm_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             tick,
    output logic             pe_enable
);

    logic     loaded;
    div_cfg_t cfg;
    logic     pre_stb;
    logic     unused_flag_bit;

    assign unused_flag_bit = wr_data[REG_W-1];

    nvm_cfg_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_cfg (wr_data[REG_W-2:0]),
        .loaded (loaded),
        .cfg    (cfg)
    );

    nvm_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (loaded),
        .use_pre (cfg.prescale),
        .stb     (pre_stb)
    );

    nvm_div_count #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (loaded),
        .stb   (pre_stb),
        .limit (cfg.divisor),
        .tick  (tick)
    );

    assign rd_data   = status_word(loaded, cfg);
    assign pe_enable = loaded;

    // R9
    tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> rd_data[REG_W-1]);

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (cfg.prescale || cfg.divisor != '0)) |=> !tick);

    // R7
    pre_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg.prescale) |=> (!tick && $stable(cfg)));

endmodule

// File: tb/nvm_tick_gen_tb.sv
module nvm_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick;
    logic       pe_enable;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nvm_tick_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tick      (tick),
        .pe_enable (pe_enable)
    );

    localparam int NV = 8;
    localparam logic [7:0] VEC_WR [NV] = '{8'h00, 8'h05, 8'h40, 8'h4C, 8'h27, 8'h3F, 8'h7F, 8'hC3};
    localparam int         VEC_P  [NV] = '{1, 6, 8, 104, 40, 64, 512, 32};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives a write across one edge; returns at the negedge of the first cycle after it.
    task automatic do_write(input logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Cycles until tick is seen, counting the current cycle as 1.
    task automatic cycles_to_tick(output int n);
        n = 1;
        while (!tick && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_interval(output int n);
        @(negedge clk);
        cycles_to_tick(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();
        // R1
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        check(pe_enable == 1'b0, "R1 pe_enable", pe_enable, 0);
        // R9: no tick while unloaded
        begin
            int seen = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (tick) seen++;
            end
            check(seen == 0, "R9 idle ticks", seen, 0);
        end

        for (int v = 0; v < NV; v++) begin
            do_reset();
            do_write(VEC_WR[v]);
            // R2 R4
            check(rd_data == {1'b1, VEC_WR[v][6:0]}, "R2 R4 rd_data", rd_data, {1'b1, VEC_WR[v][6:0]});
            // R5
            check(pe_enable == 1'b1, "R5 pe_enable", pe_enable, 1);
            // R8
            cycles_to_tick(n);
            check(n == VEC_P[v], "R8 first tick", n, VEC_P[v]);
            // R6 R7
            next_interval(n);
            check(n == VEC_P[v], VEC_WR[v][6] ? "R7 period" : "R6 period", n, VEC_P[v]);
            // R3: second write ignored
            do_write(~VEC_WR[v]);
            check(rd_data == {1'b1, VEC_WR[v][6:0]}, "R3 rd_data", rd_data, {1'b1, VEC_WR[v][6:0]});
            cycles_to_tick(n);
            next_interval(n);
            check(n == VEC_P[v], "R3 period", n, VEC_P[v]);
        end

        // R10: write during reset
        @(negedge clk);
        rst     = 1'b1;
        wr_en   = 1'b1;
        wr_data = 8'h45;
        @(negedge clk);
        rst   = 1'b0;
        wr_en = 1'b0;
        check(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
        check(pe_enable == 1'b0, "R10 pe_enable", pe_enable, 0);

        // R11: reset after load, then a new first write
        do_write(8'h02);
        check(rd_data == 8'h82, "R11 loaded", rd_data, 8'h82);
        do_reset();
        check(rd_data == 8'h00, "R11 cleared", rd_data, 0);
        check(pe_enable == 1'b0, "R11 pe_enable", pe_enable, 0);
        do_write(8'h41);
        check(rd_data == 8'hC1, "R11 reload", rd_data, 8'hC1);
        cycles_to_tick(n);
        check(n == 16, "R11 first tick", n, 16);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule